// File: doc/BRIEF.md
# Serial EEPROM Page Write Engine

This block sits behind the serial-bus controller of a two-wire EEPROM. Once the controller has decoded a write command and its two address bytes, the engine accepts the command's data bytes into a 32-byte page latch. It keeps the row address (upper address bits) fixed for the whole command and steps only the five low bits, which wrap inside the row. A commit strobe from the controller, raised only for a Stop that follows a data acknowledge, starts a self-timed programming cycle. In that cycle the latched bytes go out one per clock through a write port to the array RAM. A busy flag then stays high for the full programming time.

A write-control input guards the top quarter of the array. If it is high at any cycle from the command's Start to the cycle in which the address is taken, the engine suppresses every write of that command that targets the guarded rows. An abort strobe, or a Stop anywhere other than right after a data acknowledge, drops the latched bytes without touching the array. The programming time is a count of system clocks picked from two parameters, so a bench can use a short value.

Data enters on a valid/ready stream. `s_ready` is high only in the data phase of a command. A byte is taken in every cycle where `s_valid` and `s_ready` are both high. The controller holds `s_data` while `s_ready` is low, and it must not offer bytes outside a command. All other inputs are single-cycle strobes and are ignored while `busy` is high.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy`, `s_ready` and `mem_we` are low.
- R2: `s_ready` goes high in the cycle after `addr_valid` is taken during the address phase, which follows an accepted `cmd_start`. It stays high until the command ends, and each cycle with `s_valid && s_ready` takes one byte.
- R3: Every write of a command uses row `addr_in[12:5]` as captured. Byte k of the command lands at low bits `(addr_in[4:0] + k) mod 32`. A byte that wraps onto an earlier position replaces the older byte.
- R4: If `wr_ctrl` is 1 in any cycle from an accepted `cmd_start` through the cycle that takes `addr_valid`, no write of that command reaches addresses whose bits [12:11] are 2'b11 (1800h to 1FFFh). `wr_ctrl` after that cycle, and for rows below 1800h, has no effect.
- R5: A commit happens only on `stop_ack` in the data phase. `cmd_abort`, or `stop_ack` in the address phase, ends the command with no write and no busy period.
- R6: `stop_ack` after zero accepted data bytes starts no write and leaves `busy` low.
- R7: After a commit, `busy` stays high for exactly `LONG_TW ? CYC_LONG : CYC_SHORT` clocks. While busy, `s_ready` is low and `cmd_start`, `addr_valid`, `stop_ack` and `cmd_abort` are ignored.
- R8: The array is written in the first 32 busy cycles, at most one byte per cycle, in ascending latch-position order. Only positions that received a byte are written, so every other address in the row keeps its old value.
- R9: `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Strobe: a write command has begun (Start seen, select byte is a write) |
| cmd_abort | input | 1 | Strobe: drop the current command |
| stop_ack | input | 1 | Strobe: Stop seen on the bus |
| addr_valid | input | 1 | Strobe: `addr_in` holds the command's start address |
| addr_in | input | ADDR_W | Start byte address |
| wr_ctrl | input | 1 | Write-control level; 1 guards the top quarter |
| s_valid | input | 1 | Data byte offered |
| s_ready | output | 1 | Engine can take a data byte |
| s_data | input | DATA_W | Data byte |
| busy | output | 1 | Programming cycle running |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The bench targets row wrap at the row end and the overwrite of latch positions by a 34-byte command. An engine that carried into the row bits, or kept the first byte, would leave data in a neighbouring row or the wrong byte at the row base. The bench raises write control only in the address phase and then only in the data phase, on rows in the guarded quarter and below it. A window sampled at the wrong time either corrupts 1800h to 1FFFh or refuses lawful writes. It also runs a sparse rewrite of a single byte, which exposes an engine that writes the whole row back from stale latch contents. Aborts, a Stop during addressing, an empty command and a Start pulsed during busy show whether a spurious programming cycle starts or the busy length is off.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_BUSY = 2'd3
  } ewp_phase_e;

  function automatic logic in_guarded_quarter(input logic [1:0] row_msbs);
    return row_msbs == 2'b11;
  endfunction

endpackage

// File: rtl/ewp_guard.sv
module ewp_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic take_start,
  input  logic addr_window,
  input  logic wc,
  output logic prot
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot <= 1'b0;
    end else if (take_start) begin
      prot <= wc;
    end else if (addr_window) begin
      prot <= prot | wc;
    end
  end

endmodule

// File: rtl/ewp_latch.sv
module ewp_latch #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_vld;
  logic [SLOTS-1:0]  hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit[g] = wr_en && (wr_idx == PAGE_W'(g));

    always_ff @(posedge clk) begin
      if (hit[g]) begin
        slot_data[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
      end else if (clear) begin
        slot_vld[g] <= 1'b0;
      end else if (hit[g]) begin
        slot_vld[g] <= 1'b1;
      end
    end
  end

  assign rd_data   = slot_data[rd_idx];
  assign rd_valid  = slot_vld[rd_idx];
  assign any_valid = |slot_vld;

endmodule

// File: rtl/ewp_timer.sv
module ewp_timer #(
  parameter int TW    = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TW - 1);

  assign done = busy && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (!busy) begin
      if (go) begin
        busy  <= 1'b1;
        count <= '0;
      end
    end else if (done) begin
      busy  <= 1'b0;
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import ewp_pkg::*;
#(
  parameter int       ADDR_W    = 13,
  parameter int       DATA_W    = 8,
  parameter int       PAGE_W    = 5,
  parameter int       CYC_SHORT = 500000,
  parameter int       CYC_LONG  = 1000000,
  parameter bit       LONG_TW   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_abort,
  input  logic              stop_ack,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_ctrl,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int TW    = LONG_TW ? CYC_LONG : CYC_SHORT;
  localparam int CNT_W = $clog2(TW + 1);

  ewp_phase_e        phase;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] ptr_q;

  logic              take_start;
  logic              take_abort;
  logic              take_stop;
  logic              take_addr;
  logic              take_byte;
  logic              commit;
  logic              latch_clear;
  logic              prot;
  logic              lat_any;
  logic              lat_vld;
  logic [DATA_W-1:0] lat_data;
  logic              t_busy;
  logic              t_done;
  logic [CNT_W-1:0]  t_count;
  logic [PAGE_W-1:0] slot;
  logic              in_slots;
  logic              blocked;

  // Strobe decode; every command strobe is dead while programming.
  assign take_start = cmd_start && (phase != PH_BUSY);
  assign take_abort = cmd_abort && !cmd_start && (phase != PH_BUSY);
  assign take_stop  = stop_ack && !cmd_start && !cmd_abort && (phase != PH_BUSY);
  assign take_addr  = addr_valid && (phase == PH_ADDR) && !cmd_start && !cmd_abort && !stop_ack;
  assign take_byte  = s_valid && s_ready;
  assign commit     = take_stop && (phase == PH_DATA) && lat_any;
  assign latch_clear = take_start || take_abort || t_done;

  assign s_ready = (phase == PH_DATA);
  assign busy    = t_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      row_q <= '0;
      ptr_q <= '0;
    end else begin
      if (phase == PH_BUSY) begin
        if (t_done) begin
          phase <= PH_IDLE;
        end
      end else if (take_start) begin
        phase <= PH_ADDR;
      end else if (take_abort) begin
        phase <= PH_IDLE;
      end else if (take_stop) begin
        phase <= commit ? PH_BUSY : PH_IDLE;
      end else if (take_addr) begin
        phase <= PH_DATA;
        row_q <= addr_in[ADDR_W-1:PAGE_W];
        ptr_q <= addr_in[PAGE_W-1:0];
      end

      if (take_byte) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  ewp_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_start  (take_start),
    .addr_window (phase == PH_ADDR),
    .wc          (wr_ctrl),
    .prot        (prot)
  );

  ewp_latch #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (latch_clear),
    .wr_en     (take_byte),
    .wr_idx    (ptr_q),
    .wr_data   (s_data),
    .rd_idx    (slot),
    .rd_data   (lat_data),
    .rd_valid  (lat_vld),
    .any_valid (lat_any)
  );

  ewp_timer #(
    .TW    (TW),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (commit),
    .busy  (t_busy),
    .count (t_count),
    .done  (t_done)
  );

  // Drain: the first SLOTS busy cycles each visit one latch position.
  assign slot     = t_count[PAGE_W-1:0];
  assign in_slots = (t_count < CNT_W'(SLOTS));
  assign blocked  = prot && in_guarded_quarter(row_q[ROW_W-1 -: 2]);

  assign mem_we    = t_busy && in_slots && lat_vld && !blocked;
  assign mem_addr  = {row_q, slot};
  assign mem_wdata = lat_data;

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 5,
  parameter int TW_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_abort,
  input logic              stop_ack,
  input logic              addr_valid,
  input logic              wr_ctrl,
  input logic              s_valid,
  input logic              s_ready,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  logic        got_byte;
  logic        in_win;
  logic        seen_wc;
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_byte <= 1'b0;
      in_win   <= 1'b0;
      seen_wc  <= 1'b0;
      busy_len <= '0;
    end else begin
      busy_len <= busy ? busy_len + 1 : 32'd0;
      if (busy) begin
        got_byte <= 1'b0;
      end else if (cmd_start || cmd_abort) begin
        got_byte <= 1'b0;
      end else if (s_valid && s_ready) begin
        got_byte <= 1'b1;
      end
      if (!busy) begin
        if (cmd_start) begin
          in_win  <= 1'b1;
          seen_wc <= wr_ctrl;
        end else begin
          if (in_win) seen_wc <= seen_wc | wr_ctrl;
          if (addr_valid || cmd_abort || stop_ack) in_win <= 1'b0;
        end
      end
    end
  end

  p_we_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_no_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == TW_CYCLES));

  p_commit_needs_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_ack) && $past(got_byte)));

  p_abort_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_abort) && !$past(busy)) |-> !busy);

  p_guarded_quarter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && seen_wc) |-> (mem_addr[ADDR_W-1 -: 2] != 2'b11));

  p_row_and_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      ((mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])) &&
       (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1))));

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_W    (PAGE_W),
  .TW_CYCLES (TW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .cmd_abort  (cmd_abort),
  .stop_ack   (stop_ack),
  .addr_valid (addr_valid),
  .wr_ctrl    (wr_ctrl),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;

  localparam int TW = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        cmd_abort = 1'b0;
  logic        stop_ack = 1'b0;
  logic        addr_valid = 1'b0;
  logic [12:0] addr_in = '0;
  logic        wr_ctrl = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        busy;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W (13), .DATA_W (8), .PAGE_W (5),
    .CYC_SHORT (40), .CYC_LONG (TW), .LONG_TW (1'b1)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_abort (cmd_abort),
    .stop_ack (stop_ack), .addr_valid (addr_valid), .addr_in (addr_in),
    .wr_ctrl (wr_ctrl), .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data),
    .busy (busy), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Array image built from the design's write port; erased bytes read FFh.
  logic [7:0] img [int];
  function automatic int rd(input int a);
    return img.exists(a) ? int'(img[a]) : 8'hFF;
  endfunction

  // Behavioural reference: 0 idle, 1 addressing, 2 data, 3 programming.
  int       m_mode = 0, m_cnt = 0, m_row = 0, m_ptr = 0;
  bit       m_prot = 1'b0;
  bit [7:0] m_buf [32];
  bit       m_vld [32];

  function automatic bit m_any();
    foreach (m_vld[i]) if (m_vld[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void m_clear();
    foreach (m_vld[i]) m_vld[i] = 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_prot = 0; m_clear();
    end else if (m_mode == 3) begin
      m_cnt++;
      if (m_cnt == TW) begin m_mode = 0; m_cnt = 0; m_clear(); end
    end else if (cmd_start) begin
      m_mode = 1; m_prot = wr_ctrl; m_clear();
    end else if (cmd_abort) begin
      m_mode = 0; m_clear();
    end else begin
      bit had;
      had = m_any();
      if (m_mode == 1) m_prot = m_prot | wr_ctrl;
      if (m_mode == 2 && s_valid) begin
        m_buf[m_ptr] = s_data; m_vld[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 32;
      end
      if (stop_ack) begin
        if (m_mode == 2 && had) begin m_mode = 3; m_cnt = 0; end
        else m_mode = 0;
      end else if (m_mode == 1 && addr_valid) begin
        m_mode = 2; m_row = int'(addr_in) / 32; m_ptr = int'(addr_in) % 32;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      bit exp_we;
      exp_we = (m_mode == 3) && (m_cnt < 32) && m_vld[m_cnt % 32] &&
               !(m_prot && (m_row / 64) == 3);
      chk("R7 busy", int'(busy), int'(m_mode == 3));
      chk("R2 s_ready", int'(s_ready), int'(m_mode == 2));
      chk("R8 mem_we", int'(mem_we), int'(exp_we));
      if (exp_we && mem_we) begin
        chk("R3 mem_addr", int'(mem_addr), m_row * 32 + m_cnt);
        chk("R3 mem_wdata", int'(mem_wdata), int'(m_buf[m_cnt]));
      end
      if (mem_we) img[int'(mem_addr)] = mem_wdata;
    end
  end

  initial begin
    wait (cycles >= 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic run_cmd(input int addr, input int n, input int base,
                         input bit wc_win, input bit wc_data, input bit do_abort);
    cmd_start = 1'b1; wr_ctrl = wc_win;
    @(negedge clk); cmd_start = 1'b0;
    @(negedge clk); addr_valid = 1'b1; addr_in = 13'(addr);
    @(negedge clk); addr_valid = 1'b0; wr_ctrl = wc_data;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = 8'(base + i);
      @(negedge clk);
    end
    s_valid = 1'b0;
    if (do_abort) cmd_abort = 1'b1; else stop_ack = 1'b1;
    @(negedge clk); cmd_abort = 1'b0; stop_ack = 1'b0; wr_ctrl = 1'b0;
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    @(negedge clk);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 s_ready", int'(s_ready), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    @(negedge clk);

    // Single byte, busy length and strobes ignored while busy.
    run_cmd('h0123, 1, 'hA5, 0, 0, 0);
    repeat (5) @(negedge clk);
    cmd_start = 1'b1; wr_ctrl = 1'b1; @(negedge clk); cmd_start = 1'b0; wr_ctrl = 1'b0;
    stop_ack = 1'b1; @(negedge clk); stop_ack = 1'b0;
    wait_idle(len);
    chk("R7 busy length", len + 7, TW);
    chk("R2 byte stored", rd('h0123), 'hA5);
    chk("R3 neighbour untouched", rd('h0124), 'hFF);
    chk("R7 start during busy ignored", int'(s_ready), 0);

    // Four-byte page.
    run_cmd('h0040, 4, 'h10, 0, 0, 0); wait_idle(len);
    chk("R2 page byte 0", rd('h0040), 'h10);
    chk("R2 page byte 3", rd('h0043), 'h13);

    // Row-end wrap.
    run_cmd('h005E, 4, 'h30, 0, 0, 0); wait_idle(len);
    chk("R3 wrap 5E", rd('h005E), 'h30);
    chk("R3 wrap 5F", rd('h005F), 'h31);
    chk("R3 wrap to row base", rd('h0040), 'h32);
    chk("R3 wrap 41", rd('h0041), 'h33);
    chk("R3 no carry into next row", rd('h0060), 'hFF);

    // Sparse rewrite keeps other positions.
    run_cmd('h0042, 1, 'h77, 0, 0, 0); wait_idle(len);
    chk("R8 rewritten byte", rd('h0042), 'h77);
    chk("R8 untouched 43", rd('h0043), 'h13);
    chk("R8 untouched 41", rd('h0041), 'h33);

    // 34 bytes overwrite positions 0 and 1.
    run_cmd('h0200, 34, 'h80, 0, 0, 0); wait_idle(len);
    chk("R3 overwrite slot 0", rd('h0200), 'hA0);
    chk("R3 overwrite slot 1", rd('h0201), 'hA1);
    chk("R3 slot 2 kept", rd('h0202), 'h82);
    chk("R3 last slot", rd('h021F), 'h9F);

    // Write control.
    run_cmd('h1900, 2, 'h55, 1, 0, 0); wait_idle(len);
    chk("R4 guarded row blocked", rd('h1900), 'hFF);
    chk("R4 guarded row blocked 2", rd('h1901), 'hFF);
    run_cmd('h1A00, 1, 'h66, 0, 1, 0); wait_idle(len);
    chk("R4 wc after address ignored", rd('h1A00), 'h66);
    run_cmd('h0300, 1, 'h44, 1, 1, 0); wait_idle(len);
    chk("R4 lower quarter unaffected", rd('h0300), 'h44);

    // Abort and misplaced Stop.
    run_cmd('h0400, 3, 'hC0, 0, 0, 1);
    chk("R5 abort no busy", int'(busy), 0);
    repeat (40) @(negedge clk);
    chk("R5 abort no write", rd('h0400), 'hFF);
    cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    stop_ack = 1'b1; @(negedge clk); stop_ack = 1'b0;
    chk("R5 stop in address phase", int'(busy), 0);

    // Empty command.
    run_cmd('h0500, 0, 0, 0, 0, 0);
    chk("R6 zero bytes no busy", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R6 still idle", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule